// File: doc/BRIEF.md
# I2S Serial Audio Transmitter with Sample Queue

This block is a memory-mapped I2S master transmitter. It runs entirely on its master clock (`clk`). Software reaches it through a simple 32-bit register port. Software queues sample words through a data register into a 32-entry queue. It picks a sample width of 16 or 24 bits and programs two divider fields. The first divider sets how many master clocks make one bit clock. The second sets how many bit clocks make one frame. Software then sets a run bit. The block derives the bit clock and the word-select line from the master clock and shifts each queued word out MSB first in standard I2S framing. Each queue word carries one channel's sample, right-justified. Words are taken left, right, left, right.

A level register reports queue occupancy so software can poll for space. Software may prefill the queue before it sets the run bit. Clearing the run bit lets the current frame finish before the line goes quiet. A write to the flush register ends activity at once and empties the queue. The register slots for the receive direction, DMA and interrupts are present in the address map. They read as zero and ignore writes.

The serialiser is a three-state machine:
- SER_IDLE: outputs held low.
- SER_RUN: frames are streamed.
- SER_FINISH: the current frame completes after the run bit has been cleared.

Its transitions are:
- SER_IDLE→SER_RUN when the run bit is seen set.
- SER_RUN→SER_FINISH when the run bit is seen clear.
- SER_FINISH→SER_RUN when the run bit is set again before the frame ends.
- SER_FINISH→SER_IDLE at the end of the last bit of the frame.
- Any state→SER_IDLE on a flush write.

Top module: `i2s_tx_ctrl`

## Requirements
- R1: After reset the format register (0x00) reads 15, the clock register (0x08) reads 0x0007001F, the level register (0x0C) and run register (0x1C) read 0, and `sclk`, `ws` and `sdo` are low.
- R2: Offsets 0x04, 0x10, 0x14, 0x18 and 0x28 always read zero and ignore writes. Run register bit 1 and clock register bits [15:8] read zero, store nothing and start nothing.
- R3: Format register bits [4:0] hold sample width minus one. A write is taken only when that field is 15 or 23; any other write leaves the field unchanged.
- R4: Every write to offset 0x24 pushes the full 32-bit word into the queue, whether or not the run bit is set. Level register bits [5:0] give the queue occupancy.
- R5: Once running, the bit clock period is clock register bits [23:16] plus one master clocks. `sdo` and `ws` change only at a falling edge of `sclk`.
- R6: A frame is clock register bits [7:0] plus one bit clocks, split into two equal slots, left then right. `ws` is low for the left slot and high for the right slot, and it changes one bit clock before each slot's first bit.
- R7: Each slot sends the low (width) bits of its word MSB first. Word bits above the width are ignored. Slot bits after the sample are zero.
- R8: A data write while the queue holds 32 words is dropped. The level stays at 32, and the dropped word is never sent.
- R9: When a slot starts with the queue empty, the slot is sent as all zeros and transmission continues.
- R10: Setting run bit 0 starts a frame whose left slot carries the oldest queued word. Clearing it lets the current frame finish, after which `sclk` stays low.
- R11: A write of any value to offset 0x20 empties the queue, returns the serialiser to idle with outputs low, and clears the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select: low for left, high for right |
| sdo | output | 1 | Serial data, MSB first |

## Verification
Slot boundaries are the main target. A design that places `ws` on the MSB bit instead of one bit ahead, or that pops the queue at the wrong bit, makes every captured frame differ from the model from the first slot on. The bench also drives 24-bit samples in 32-bit slots with junk in the upper word bits. A design that sends the upper bits or pads at the wrong end would shift garbage into the stream.

Further scenarios:
- The queue is overfilled by one word. A design that overwrites the head or counts past 32 would then send the dropped word.
- The run bit is dropped mid-frame. A design that stops at once would leave a partial frame.
- A flush is issued mid-stream. A design that keeps the run bit, or keeps stale queue data, would resume on its own or replay old words at the next start.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int ADDR_W = 6;
    localparam int WORD_W = 32;
    localparam int DIV_W  = 8;
    localparam int WCODE_W = 5;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_FMT     = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RXFMT   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CLKDIV  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_LEVEL   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DMACTL  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_IRQEN   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IRQST   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RUN     = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_FLUSH   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_TXWORD  = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_RXWORD  = 6'h28;

    // legal width codes (width minus one)
    localparam logic [WCODE_W-1:0] WCODE_16 = 5'd15;
    localparam logic [WCODE_W-1:0] WCODE_24 = 5'd23;

    // reset values of the divider fields
    localparam logic [DIV_W-1:0] MDIV_RST = 8'd7;
    localparam logic [DIV_W-1:0] FDIV_RST = 8'd31;

    typedef enum logic [1:0] {
        SER_IDLE   = 2'd0,
        SER_RUN    = 2'd1,
        SER_FINISH = 2'd2
    } ser_state_e;

endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
    import i2s_tx_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [LVL_W-1:0]     fifo_level,
    output logic [WCODE_W-1:0]   width_code,
    output logic [DIV_W-1:0]     mclk_div,
    output logic [DIV_W-1:0]     frame_div,
    output logic                 tx_en,
    output logic                 push,
    output logic                 flush
);

    logic [WCODE_W-1:0] wcode_in;
    logic               wcode_ok;

    assign wcode_in = bus_wdata[WCODE_W-1:0];
    assign wcode_ok = (wcode_in == WCODE_16) || (wcode_in == WCODE_24);
    assign push     = bus_wr && (bus_addr == OFS_TXWORD);
    assign flush    = bus_wr && (bus_addr == OFS_FLUSH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_code <= WCODE_16;
            mclk_div   <= MDIV_RST;
            frame_div  <= FDIV_RST;
            tx_en      <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_FMT: begin
                    if (wcode_ok) width_code <= wcode_in;
                end
                OFS_CLKDIV: begin
                    mclk_div  <= bus_wdata[23:16];
                    frame_div <= bus_wdata[DIV_W-1:0];
                end
                OFS_RUN:   tx_en <= bus_wdata[0];
                OFS_FLUSH: tx_en <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_FMT:    bus_rdata = {{(WORD_W-WCODE_W){1'b0}}, width_code};
            OFS_CLKDIV: bus_rdata = {8'h00, mclk_div, 8'h00, frame_div};
            OFS_LEVEL:  bus_rdata = {{(WORD_W-LVL_W){1'b0}}, fifo_level};
            OFS_RUN:    bus_rdata = {{(WORD_W-1){1'b0}}, tx_en};
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter  int DEPTH = 32,
    parameter  int W     = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             flush,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             bit_end
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   hi_start;

    // high phase covers the upper half of the count range
    assign hi_start = ({1'b0, div} + 1'b1) >> 1;
    assign sclk     = run && ({1'b0, cnt} >= hi_start);
    assign bit_end  = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || flush || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2s_tx_serial.sv
module i2s_tx_serial
    import i2s_tx_pkg::*;
#(
    parameter  int DW = 8,
    parameter  int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               tx_en,
    input  logic [DW-1:0]      frame_div,
    input  logic [WCODE_W-1:0] width_code,
    input  logic               bit_end,
    input  logic               fifo_empty,
    input  logic [W-1:0]       fifo_head,
    output logic               fifo_pop,
    output logic               run,
    output logic               ws,
    output logic               sdo
);

    ser_state_e    state, nxt;
    logic [DW-1:0] bitc;
    logic [W-1:0]  cur;

    logic [DW:0]   half, bitc_x, nb_x, s_x, width_n, idx;
    logic [DW-1:0] nb;
    logic          last_bit, start, slot_edge, load;

    assign half     = ({1'b0, frame_div} + 1'b1) >> 1;
    assign last_bit = (bitc == frame_div);
    assign nb       = last_bit ? '0 : bitc + 1'b1;
    assign bitc_x   = {1'b0, bitc};
    assign nb_x     = {1'b0, nb};
    assign s_x      = (bitc_x >= half) ? bitc_x - half : bitc_x;
    assign width_n  = {{(DW-4){1'b0}}, width_code} + 1'b1;
    assign idx      = width_n - 1'b1 - s_x;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            SER_IDLE:   if (tx_en) nxt = SER_RUN;
            SER_RUN:    if (!tx_en) nxt = SER_FINISH;
            SER_FINISH: begin
                if (tx_en)                     nxt = SER_RUN;
                else if (bit_end && last_bit)  nxt = SER_IDLE;
            end
            default:    nxt = SER_IDLE;
        endcase
        if (flush) nxt = SER_IDLE;
    end

    assign start     = (state == SER_IDLE) && (nxt == SER_RUN);
    assign slot_edge = bit_end && (nxt != SER_IDLE) && ((nb_x == half) || (nb == '0));
    assign load      = start || slot_edge;
    assign fifo_pop  = load && !fifo_empty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SER_IDLE;
            bitc  <= '0;
            cur   <= '0;
        end else if (flush) begin
            state <= SER_IDLE;
            bitc  <= '0;
            cur   <= '0;
        end else begin
            state <= nxt;
            if (start)        bitc <= '0;
            else if (bit_end) bitc <= nb;
            if (load)         cur  <= fifo_empty ? '0 : fifo_head;
        end
    end

    // outputs
    always_comb begin
        run = (state != SER_IDLE);
        ws  = run && (nb_x >= half);
        sdo = 1'b0;
        if (run && (s_x < width_n)) sdo = cur[idx[IW-1:0]];
    end

endmodule

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
    import i2s_tx_pkg::*;
#(
    parameter  int FIFO_DEPTH = 32,
    localparam int LVL_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              ws,
    output logic              sdo
);

    logic [WCODE_W-1:0] width_code;
    logic [DIV_W-1:0]   mclk_div, frame_div;
    logic               tx_en, push, flush;
    logic [LVL_W-1:0]   fifo_level;
    logic [WORD_W-1:0]  fifo_head;
    logic               fifo_empty, fifo_full, fifo_pop;
    logic               run, bit_end;

    i2s_tx_regs #(.LVL_W(LVL_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fifo_level (fifo_level),
        .width_code (width_code),
        .mclk_div   (mclk_div),
        .frame_div  (frame_div),
        .tx_en      (tx_en),
        .push       (push),
        .flush      (flush)
    );

    i2s_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (bus_wdata),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_level)
    );

    i2s_bclk_gen #(.DIV_W(DIV_W)) bclk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .flush   (flush),
        .div     (mclk_div),
        .sclk    (sclk),
        .bit_end (bit_end)
    );

    i2s_tx_serial #(.DW(DIV_W), .W(WORD_W)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .tx_en      (tx_en),
        .frame_div  (frame_div),
        .width_code (width_code),
        .bit_end    (bit_end),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .fifo_pop   (fifo_pop),
        .run        (run),
        .ws         (ws),
        .sdo        (sdo)
    );

endmodule

// File: rtl/i2s_tx_ctrl_chk.sv
module i2s_tx_ctrl_chk
    import i2s_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int LVL_W      = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [LVL_W-1:0]   level,
    input logic [WCODE_W-1:0] width_code,
    input logic               sclk,
    input logic               ws,
    input logic               sdo
);

    logic flush_wr;
    assign flush_wr = bus_wr && (bus_addr == OFS_FLUSH);

    // R3: only the two legal width codes are ever held
    a_r3_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (width_code == WCODE_16) || (width_code == WCODE_24));

    // R8: occupancy never exceeds the queue depth
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(FIFO_DEPTH));

    // R4: occupancy moves by at most one word per cycle unless flushed
    a_r4_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_wr |=> (level == $past(level)) || (level == $past(level) + 1'b1)
                   || (level + 1'b1 == $past(level)));

    // R11: a flush write empties the queue and silences the outputs
    a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (level == '0) && !sclk && !ws && !sdo);

    // R5: data and word select hold while the bit clock stays high
    a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> ($stable(sdo) && $stable(ws)));

    // R6: word select moves only together with a falling bit clock
    a_r6_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ws) && !$past(flush_wr)) |-> $fell(sclk));

endmodule

bind i2s_tx_ctrl i2s_tx_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .level      (fifo_level),
    .width_code (width_code),
    .sclk       (sclk),
    .ws         (ws),
    .sdo        (sdo)
);

// File: tb/i2s_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_ctrl_tb_top;

    localparam int CAPMAX = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, ws, sdo;

    int checks = 0;
    int errors = 0;

    logic        cap_ws [CAPMAX];
    logic        cap_sd [CAPMAX];
    longint      cap_cy [CAPMAX];
    int          cap_n = 0;
    longint      cyc = 0;
    logic        sclk_d = 1'b0;

    logic [31:0] exp_w [64];
    int          exp_n = 0;

    always #5 clk = ~clk;

    i2s_tx_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .ws        (ws),
        .sdo       (sdo)
    );

    // capture ws/sdo at each rising bit clock, sampled away from the edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk && !sclk_d && cap_n < CAPMAX) begin
            cap_ws[cap_n] = ws;
            cap_sd[cap_n] = sdo;
            cap_cy[cap_n] = cyc;
            cap_n = cap_n + 1;
        end
        sclk_d = sclk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_bits(input int n);
        while (cap_n < n) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // compare captured bits with the frame model built from the requirements
    task automatic verify_stream(input string req, input int nbits, input int width,
                                 input int half);
        int bad = 0;
        int first = -1;
        logic fe_sd = 1'b0, fe_ws = 1'b0, fa_sd = 1'b0, fa_ws = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            int b = i % (2 * half);
            int f = i / (2 * half);
            int k = 2 * f + ((b >= half) ? 1 : 0);
            int s = b % half;
            logic [31:0] w = (k < exp_n) ? exp_w[k] : 32'h0;
            logic e_sd = (s < width) ? w[width - 1 - s] : 1'b0;
            logic e_ws = (((b + 1) % (2 * half)) >= half);
            if (cap_sd[i] !== e_sd || cap_ws[i] !== e_ws) begin
                if (bad == 0) begin
                    first = i; fe_sd = e_sd; fe_ws = e_ws; fa_sd = cap_sd[i]; fa_ws = cap_ws[i];
                end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("stream bit %0d {ws,sdo}", first),
              {fa_ws, fa_sd}, {fe_ws, fe_sd});
    endtask

    task automatic verify_period(input string req, input int nbits, input int period);
        int bad_at = -1;
        longint d = 0;
        for (int i = 1; i < nbits; i++) begin
            if (bad_at < 0 && (cap_cy[i] - cap_cy[i-1]) != period) begin
                bad_at = i; d = cap_cy[i] - cap_cy[i-1];
            end
        end
        check(bad_at < 0, req, "bit clock period", (bad_at < 0) ? period : d, period);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(!sclk && !ws && !sdo, "R1", "idle outputs", {sclk, ws, sdo}, 0);
        rd(6'h00, d); check(d == 32'd15, "R1", "format reset", d, 15);
        rd(6'h08, d); check(d == 32'h0007001F, "R1", "clock reset", d, 32'h0007001F);
        rd(6'h0C, d); check(d == 32'd0, "R1", "level reset", d, 0);
        rd(6'h1C, d); check(d == 32'd0, "R1", "run reset", d, 0);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        int bad = 0;
        logic [5:0] ofs [5] = '{6'h04, 6'h10, 6'h14, 6'h18, 6'h28};
        foreach (ofs[i]) begin
            wr(ofs[i], 32'hFFFF_FFFF);
            rd(ofs[i], d);
            if (d != 0) bad++;
        end
        check(bad == 0, "R2", "unused registers read zero", bad, 0);
        wr(6'h08, 32'h0007AB1F);
        rd(6'h08, d); check(d == 32'h0007001F, "R2", "clock bits 15:8 ignored", d, 32'h0007001F);
        cap_n = 0;
        wr(6'h1C, 32'h2);
        idle_cycles(60);
        rd(6'h1C, d); check(d == 32'd0, "R2", "run bit 1 reads zero", d, 0);
        check(cap_n == 0 && !sclk, "R2", "run bit 1 starts nothing", cap_n, 0);
    endtask

    task automatic t_width();
        logic [31:0] d;
        wr(6'h00, 32'hFFFF_FFF7);           // code 23, upper bits junk
        rd(6'h00, d); check(d == 32'd23, "R3", "width 24 accepted", d, 23);
        wr(6'h00, 32'd7);
        rd(6'h00, d); check(d == 32'd23, "R3", "illegal width ignored", d, 23);
        wr(6'h00, 32'd31);
        rd(6'h00, d); check(d == 32'd23, "R3", "code 31 ignored", d, 23);
        wr(6'h00, 32'd15);
        rd(6'h00, d); check(d == 32'd15, "R3", "width 16 accepted", d, 15);
    endtask

    task automatic t_level();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) wr(6'h24, 32'h100 + i);
        rd(6'h0C, d); check(d == 32'd5, "R4", "level after 5 pushes while stopped", d, 5);
        for (int i = 0; i < 30; i++) wr(6'h24, 32'h200 + i);
        rd(6'h0C, d); check(d == 32'd32, "R8", "level saturates at 32", d, 32);
        wr(6'h20, 32'h0);
        rd(6'h0C, d); check(d == 32'd0, "R11", "flush empties queue", d, 0);
    endtask

    task automatic t_stream16();
        logic [31:0] d;
        int n_end;
        wr(6'h00, 32'd15);
        wr(6'h08, 32'h0007001F);           // ratio 8, 32-bit frame
        exp_w[0] = 32'hDEAD_A5C3; exp_w[1] = 32'h1234_0F0F;
        exp_w[2] = 32'hFFFF_8001; exp_w[3] = 32'h0000_7FFE;
        exp_n = 4;
        for (int i = 0; i < 4; i++) wr(6'h24, exp_w[i]);
        cap_n = 0;
        wr(6'h1C, 32'h1);
        wait_bits(96);
        verify_stream("R6 R7 R9 R10", 96, 16, 16);
        verify_period("R5", 96, 8);
        wr(6'h1C, 32'h0);
        idle_cycles(32 * 8 * 2 + 20);
        n_end = cap_n;
        check((n_end % 32) == 0 && n_end >= 96, "R10", "stop on frame boundary (bits)", n_end, 96);
        check(!sclk && !ws && !sdo, "R10", "outputs low after stop", {sclk, ws, sdo}, 0);
        rd(6'h0C, d); check(d == 32'd0, "R9", "queue drained", d, 0);
    endtask

    task automatic t_full_drop();
        logic [31:0] d;
        wr(6'h20, 32'h0);
        wr(6'h08, 32'h0001001F);           // ratio 2
        exp_n = 32;
        for (int i = 0; i < 32; i++) begin
            exp_w[i] = 32'h0000_4000 + 32'(i * 517);
            wr(6'h24, exp_w[i]);
        end
        wr(6'h24, 32'h0000_FFFF);          // dropped
        rd(6'h0C, d); check(d == 32'd32, "R8", "level after overfill", d, 32);
        cap_n = 0;
        wr(6'h1C, 32'h1);
        wait_bits(32 * 16 + 64);
        verify_stream("R8", 32 * 16 + 64, 16, 16);
        wr(6'h1C, 32'h0);
        idle_cycles(200);
    endtask

    task automatic t_stream24_flush();
        logic [31:0] d;
        int held;
        wr(6'h20, 32'h0);
        wr(6'h00, 32'd23);
        wr(6'h08, 32'h0003003F);           // ratio 4, 64-bit frame
        exp_w[0] = 32'hAB96_5A3C; exp_w[1] = 32'hFF00_0001;
        exp_w[2] = 32'h11C0_FFEE; exp_w[3] = 32'h0080_0000;
        exp_n = 4;
        for (int i = 0; i < 4; i++) wr(6'h24, exp_w[i]);
        cap_n = 0;
        wr(6'h1C, 32'h1);
        wait_bits(128);
        verify_stream("R7", 128, 24, 32);
        verify_period("R5", 128, 4);
        // queue is empty now; load more and flush mid-stream
        for (int i = 0; i < 3; i++) wr(6'h24, 32'h00AA_AA00 + i);
        wait_bits(cap_n + 10);
        wr(6'h20, 32'h5A5A_5A5A);
        rd(6'h1C, d); check(d == 32'd0, "R11", "flush clears run bit", d, 0);
        rd(6'h0C, d); check(d == 32'd0, "R11", "flush empties queue mid-run", d, 0);
        held = cap_n;
        idle_cycles(300);
        check(cap_n == held && !sclk && !ws && !sdo, "R11", "no activity after flush",
              cap_n, held);
        // restart: new oldest word goes to the left slot of the first frame
        exp_w[0] = 32'h0012_3456; exp_w[1] = 32'h00FE_DCBA; exp_n = 2;
        wr(6'h24, exp_w[0]); wr(6'h24, exp_w[1]);
        cap_n = 0;
        wr(6'h1C, 32'h1);
        wait_bits(128);
        verify_stream("R10", 128, 24, 32);
        wr(6'h1C, 32'h0);
        idle_cycles(600);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_cycles(4);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_unused();
        t_width();
        t_level();
        t_stream16();
        t_full_drop();
        t_stream24_flush();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule